// File: doc/BRIEF.md
# Instruction Cache with Next-Line Prefetch

This block is a read-only instruction cache that sits between a fetch unit and a line-wide memory read port. It holds 4 KB in two ways of 128 sets each, with 16-byte lines. It serves 32-bit instruction words to one fetch port and handles no data traffic. A hit returns its word on the cycle after the request. A miss asks memory for the whole line. The fetch port then stalls until that line arrives.

Each accepted fetch also looks up the line that follows the one being read. When that line is absent, a background read for it is queued. Sequential code therefore finds its next line already resident. Prefetch fills use the same victim choice as demand fills. Only one memory read is ever open at a time. A demand miss that is waiting is issued ahead of a queued prefetch. A prefetch that has already been issued always completes first. Three counters expose demand hits, demand misses and prefetches issued, so the effect of prefetching can be measured. A single input clears every line.

Top module: `instr_cache_pf`

## Requirements
- R1: An accepted fetch (`fetch_req` high while `fetch_ready` is high) that hits raises `fetch_valid` on the following cycle with the addressed word. `fetch_ready` is high whenever no demand miss is waiting.
- R2: An accepted fetch that misses issues a `mem_req` pulse carrying its line address. `fetch_ready` stays low until the word is returned, which happens on the cycle after the fill response.
- R3: `fetch_addr` is a word address. Its two low bits k select word k of the line, and word k is `mem_rdata[32k+31:32k]`.
- R4: When an accepted fetch reads line N and line N+1 is not resident, a read of line N+1 is queued. The line number wraps from all ones to zero.
- R5: No prefetch is queued when line N+1 is already resident.
- R6: When a demand miss and a queued prefetch are both waiting on an idle port, the demand line is requested first.
- R7: At most one memory read is open; `mem_req` never repeats before `mem_rvalid`. A prefetch triggered while another prefetch is queued or open is dropped.
- R8: A demand miss that arrives while a prefetch read is open is requested only after that prefetch's fill.
- R9: A demand miss to the line whose prefetch is open waits for that fill and issues no second request for it.
- R10: The set index is line-address bits [6:0] (byte-address bits [10:4]). A fill goes to an invalid way if one exists, else to the least recently used way. Demand and prefetch fills share this rule, and hits refresh recency.
- R11: A cycle with `inv_all` high makes every line non-resident.
- R12: `hit_cnt` counts accepted hits, `miss_cnt` counts accepted misses, and `pf_cnt` counts prefetch reads issued. Each counter steps by one.
- R13: After reset, `fetch_ready` is high, `fetch_valid` and `mem_req` are low, all counters read zero and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear every line this cycle |
| fetch_req | input | 1 | Fetch request, one cycle per fetch |
| fetch_addr | input | 30 | Word address of the fetch |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_valid | output | 1 | Returned word is valid |
| fetch_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | One-cycle memory line read request |
| mem_line | output | 28 | Line address of the open read |
| mem_rvalid | input | 1 | Memory line response valid |
| mem_rdata | input | 128 | Memory line response data |
| hit_cnt | output | 16 | Demand hit counter |
| miss_cnt | output | 16 | Demand miss counter |
| pf_cnt | output | 16 | Prefetch read counter |

## Verification
The main check is an address sequence that mixes cold misses, sequential hits on prefetched lines, revisits within a line, and three tags competing for one pair of sets. For every fetch the bench compares the hit or miss outcome and the number of memory reads. This separates a correct prefetch from a missing or duplicated one, and a least-recently-used victim from any other choice, including a prefetch evicting a line in demand use. Directed runs with a slow memory observe the order of requested lines. They show that a queued prefetch loses to a demand, that an issued prefetch finishes first, and that a demand to a line being prefetched merges with that fill. Further directed runs cover address wrap at the top line and the effect of the clear input.

// File: rtl/instr_cache_pf.sv
module instr_cache_pf #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int CACHE_BYTES = 4096,
  parameter int CNT_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inv_all,
  input  logic                    fetch_req,
  input  logic [ADDR_W-1:2]       fetch_addr,
  output logic                    fetch_ready,
  output logic                    fetch_valid,
  output logic [31:0]             fetch_data,
  output logic                    mem_req,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_line,
  input  logic                    mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  output logic [CNT_W-1:0]        hit_cnt,
  output logic [CNT_W-1:0]        miss_cnt,
  output logic [CNT_W-1:0]        pf_cnt
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int WSEL_W    = OFF_W - 2;
  localparam int SETS      = CACHE_BYTES / (LINE_BYTES * 2);
  localparam int IDX_W     = $clog2(SETS);
  localparam int LINE_W    = ADDR_W - OFF_W;
  localparam int TAG_W     = LINE_W - IDX_W;
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [SETS-1:0]      valid_q [2];
  logic [TAG_W-1:0]     tag_q   [2][SETS];
  logic [LINE_BITS-1:0] data_q  [2][SETS];
  logic [SETS-1:0]      lru_q;

  logic              pf_pend_q, dem_pend_q, mem_bsy_q, mem_pf_q, mem_req_q, rsp_v_q;
  logic [LINE_W-1:0] pf_line_q, dem_line_q, mem_line_q;
  logic [WSEL_W-1:0] dem_wsel_q;
  logic [31:0]       rsp_d_q;
  logic [CNT_W-1:0]  hit_q, miss_q, pfc_q;

  function automatic logic present(input logic w, input logic [LINE_W-1:0] ln);
    return valid_q[w][ln[IDX_W-1:0]] && (tag_q[w][ln[IDX_W-1:0]] == ln[LINE_W-1:IDX_W]);
  endfunction

  function automatic logic [31:0] pick(input logic [LINE_BITS-1:0] ln, input logic [WSEL_W-1:0] w);
    return ln[{w, 5'b0} +: 32];
  endfunction

  logic [LINE_W-1:0] acc_line, nl_line;
  logic [IDX_W-1:0]  acc_idx, f_idx;
  logic [WSEL_W-1:0] acc_wsel;
  logic              acc, acc_h0, acc_h1, acc_hit, nl_hit, fill, fill_match;
  logic              pf_trig, issue_dem, issue_pf, f_way;

  assign fetch_ready = !dem_pend_q;
  assign acc        = fetch_req && fetch_ready;
  assign acc_line   = fetch_addr[ADDR_W-1:OFF_W];
  assign acc_wsel   = fetch_addr[OFF_W-1:2];
  assign acc_idx    = acc_line[IDX_W-1:0];
  assign nl_line    = acc_line + 1'b1;
  assign acc_h0     = present(1'b0, acc_line);
  assign acc_h1     = present(1'b1, acc_line);
  assign acc_hit    = acc_h0 || acc_h1;
  assign nl_hit     = present(1'b0, nl_line) || present(1'b1, nl_line);
  assign fill       = mem_rvalid && mem_bsy_q;
  assign fill_match = fill && (mem_line_q == acc_line);
  assign pf_trig    = acc && !nl_hit && !pf_pend_q &&
                      !(mem_bsy_q && (mem_pf_q || mem_line_q == nl_line));
  assign issue_dem  = dem_pend_q && !mem_bsy_q;
  assign issue_pf   = pf_pend_q && !mem_bsy_q && !dem_pend_q;
  assign f_idx      = mem_line_q[IDX_W-1:0];
  assign f_way      = !valid_q[0][f_idx] ? 1'b0 : (!valid_q[1][f_idx] ? 1'b1 : lru_q[f_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q[0] <= '0;
      valid_q[1] <= '0;
      lru_q      <= '0;
      pf_pend_q  <= 1'b0;
      dem_pend_q <= 1'b0;
      mem_bsy_q  <= 1'b0;
      mem_pf_q   <= 1'b0;
      mem_req_q  <= 1'b0;
      rsp_v_q    <= 1'b0;
      rsp_d_q    <= '0;
      pf_line_q  <= '0;
      dem_line_q <= '0;
      dem_wsel_q <= '0;
      mem_line_q <= '0;
      hit_q      <= '0;
      miss_q     <= '0;
      pfc_q      <= '0;
    end else begin
      rsp_v_q   <= 1'b0;
      mem_req_q <= 1'b0;
      if (acc) begin
        if (acc_hit) begin
          rsp_v_q        <= 1'b1;
          rsp_d_q        <= pick(data_q[acc_h1][acc_idx], acc_wsel);
          lru_q[acc_idx] <= !acc_h1;
          hit_q          <= hit_q + 1'b1;
        end else begin
          miss_q <= miss_q + 1'b1;
          if (fill_match) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= pick(mem_rdata, acc_wsel);
          end else begin
            dem_pend_q <= 1'b1;
            dem_line_q <= acc_line;
            dem_wsel_q <= acc_wsel;
          end
        end
        if (pf_trig) begin
          pf_pend_q <= 1'b1;
          pf_line_q <= nl_line;
        end
      end
      if (issue_dem) begin
        mem_req_q  <= 1'b1;
        mem_bsy_q  <= 1'b1;
        mem_pf_q   <= 1'b0;
        mem_line_q <= dem_line_q;
        if (pf_pend_q && pf_line_q == dem_line_q) pf_pend_q <= 1'b0;
      end else if (issue_pf) begin
        mem_req_q  <= 1'b1;
        mem_bsy_q  <= 1'b1;
        mem_pf_q   <= 1'b1;
        mem_line_q <= pf_line_q;
        pf_pend_q  <= 1'b0;
        pfc_q      <= pfc_q + 1'b1;
      end
      if (fill) begin
        mem_bsy_q             <= 1'b0;
        valid_q[f_way][f_idx] <= 1'b1;
        lru_q[f_idx]          <= !f_way;
        if (dem_pend_q && dem_line_q == mem_line_q) begin
          dem_pend_q <= 1'b0;
          rsp_v_q    <= 1'b1;
          rsp_d_q    <= pick(mem_rdata, dem_wsel_q);
        end
      end
      if (inv_all) begin
        valid_q[0] <= '0;
        valid_q[1] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[f_way][f_idx]  <= mem_line_q[LINE_W-1:IDX_W];
      data_q[f_way][f_idx] <= mem_rdata;
    end
  end

  assign fetch_valid = rsp_v_q;
  assign fetch_data  = rsp_d_q;
  assign mem_req     = mem_req_q;
  assign mem_line    = mem_line_q;
  assign hit_cnt     = hit_q;
  assign miss_cnt    = miss_q;
  assign pf_cnt      = pfc_q;
endmodule

// File: rtl/instr_cache_pf_chk.sv
module instr_cache_pf_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_ready,
  input logic             fetch_valid,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] miss_cnt,
  input logic [CNT_W-1:0] pf_cnt
);
  logic rd_open;

  always_ff @(posedge clk) begin
    if (!rst_n)          rd_open <= 1'b0;
    else if (mem_rvalid) rd_open <= 1'b0;
    else if (mem_req)    rd_open <= 1'b1;
  end

  assert_hit_reply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt != $past(hit_cnt)) |-> fetch_valid);

  assert_miss_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != $past(miss_cnt) && !fetch_valid) |-> !fetch_ready);

  assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rd_open);

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_pf_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_cnt != $past(pf_cnt)) |-> mem_req);

  assert_hit_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt - $past(hit_cnt)) <= CNT_W'(1));
endmodule

bind instr_cache_pf instr_cache_pf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_ready (fetch_ready),
  .fetch_valid (fetch_valid),
  .mem_req     (mem_req),
  .mem_rvalid  (mem_rvalid),
  .hit_cnt     (hit_cnt),
  .miss_cnt    (miss_cnt),
  .pf_cnt      (pf_cnt)
);

// File: tb/test_instr_cache_pf.sv
`timescale 1ns/1ps
module test_instr_cache_pf;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inv_all = 1'b0;
  logic         fetch_req = 1'b0;
  logic [31:2]  fetch_addr = '0;
  logic         fetch_ready, fetch_valid, mem_req;
  logic [31:0]  fetch_data;
  logic [27:0]  mem_line;
  logic         mem_rvalid = 1'b0;
  logic [127:0] mem_rdata = '0;
  logic [15:0]  hit_cnt, miss_cnt, pf_cnt;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  instr_cache_pf i_instr_cache_pf (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .mem_req(mem_req), .mem_line(mem_line), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .pf_cnt(pf_cnt)
  );

  // memory model: fixed latency, each word encodes its own word address
  int          lat = 3;
  int          mcnt = 0;
  logic        mbusy = 1'b0;
  logic [27:0] mline = '0;
  logic [27:0] rlog [64];
  int          req_total = 0;

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mbusy) begin
      if (mcnt <= 1) begin
        mem_rvalid = 1'b1;
        for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = {mline, k[1:0], 2'b10};
        mbusy = 1'b0;
      end else mcnt--;
    end
    if (mem_req) begin
      rlog[req_total % 64] = mem_line;
      req_total++;
      mline = mem_line;
      mcnt  = lat;
      mbusy = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int cyc);
    while (!fetch_ready) @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a[31:2];
    @(negedge clk);
    fetch_req = 1'b0;
    cyc = 1;
    while (!fetch_valid) begin @(negedge clk); cyc++; end
    d = fetch_data;
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {a[31:2], 2'b10};
  endfunction

  // {byte address, expect hit, memory reads expected}
  localparam logic [34:0] VEC [13] = '{
    {32'h0000_1000, 1'b0, 2'd2}, {32'h0000_1010, 1'b1, 2'd1}, {32'h0000_1024, 1'b1, 2'd1},
    {32'h0000_1008, 1'b1, 2'd0}, {32'h0000_2000, 1'b0, 2'd2}, {32'h0000_1000, 1'b1, 2'd0},
    {32'h0000_3000, 1'b0, 2'd2}, {32'h0000_1000, 1'b1, 2'd1}, {32'h0000_2000, 1'b0, 2'd2},
    {32'h0000_1010, 1'b1, 2'd0}, {32'h0000_3010, 1'b0, 2'd2}, {32'h0000_2014, 1'b0, 2'd2},
    {32'h0000_3018, 1'b1, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc, r0, h0, m0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready && !fetch_valid && !mem_req, "R13 idle outputs",
        {fetch_ready, fetch_valid, mem_req}, 3'b100);
    chk(hit_cnt == 0 && miss_cnt == 0 && pf_cnt == 0, "R13 counters", hit_cnt + miss_cnt + pf_cnt, 0);

    for (int i = 0; i < 13; i++) begin
      logic [31:0] a;
      a = VEC[i][34:3];
      h0 = hit_cnt; m0 = miss_cnt; r0 = req_total;
      do_fetch(a, d, cyc);
      repeat (20) @(negedge clk);
      chk(d == exp_word(a), $sformatf("R3 data v%0d", i), d, exp_word(a));
      chk((hit_cnt - h0) == int'(VEC[i][2]) && (miss_cnt - m0) == int'(!VEC[i][2]),
          $sformatf("R10 hit/miss v%0d", i), hit_cnt - h0, VEC[i][2]);
      chk((req_total - r0) == int'(VEC[i][1:0]),
          $sformatf("R4 R5 reads v%0d", i), req_total - r0, VEC[i][1:0]);
      if (VEC[i][2]) chk(cyc == 1, $sformatf("R1 hit latency v%0d", i), cyc, 1);
    end
    chk(hit_cnt == 7 && miss_cnt == 6 && pf_cnt == 9, "R12 totals",
        {hit_cnt, miss_cnt, pf_cnt}, {16'd7, 16'd6, 16'd9});

    // wrap at top line, demand before queued prefetch
    r0 = req_total;
    do_fetch(32'hFFFF_FFF4, d, cyc);
    repeat (20) @(negedge clk);
    chk(d == exp_word(32'hFFFF_FFF4), "R3 top word", d, exp_word(32'hFFFF_FFF4));
    chk(rlog[r0 % 64] == 28'hFFF_FFFF, "R6 demand first", rlog[r0 % 64], 28'hFFF_FFFF);
    chk(rlog[(r0 + 1) % 64] == 28'h000_0000, "R4 wrap to zero", rlog[(r0 + 1) % 64], 0);

    // open prefetch finishes before a new demand; extra prefetch dropped
    lat = 20;
    r0 = req_total;
    do_fetch(32'h0000_5000, d, cyc);
    do_fetch(32'h0000_6000, d, cyc);
    repeat (60) @(negedge clk);
    chk(d == exp_word(32'h0000_6000), "R2 miss data", d, exp_word(32'h0000_6000));
    chk(cyc > 25, "R8 demand waited", cyc, 26);
    chk(rlog[(r0 + 1) % 64] == 28'h000_0501 && rlog[(r0 + 2) % 64] == 28'h000_0600,
        "R8 order", rlog[(r0 + 2) % 64], 28'h000_0600);
    chk(req_total - r0 == 3, "R7 one open read", req_total - r0, 3);

    // demand to line whose prefetch is open
    r0 = req_total; m0 = miss_cnt;
    do_fetch(32'h0000_7000, d, cyc);
    fetch_req = 1'b1; fetch_addr = 30'h0000_7018 >> 2;
    @(negedge clk);
    fetch_req = 1'b0;
    chk(!fetch_ready, "R2 stall while waiting", fetch_ready, 0);
    while (!fetch_valid) @(negedge clk);
    d = fetch_data;
    repeat (60) @(negedge clk);
    chk(d == exp_word(32'h0000_7018), "R9 merged data", d, exp_word(32'h0000_7018));
    chk(req_total - r0 == 2, "R9 no duplicate", req_total - r0, 2);
    chk(miss_cnt - m0 == 2, "R12 misses", miss_cnt - m0, 2);

    // clear all
    lat = 3;
    do_fetch(32'h0000_8040, d, cyc);
    repeat (20) @(negedge clk);
    h0 = hit_cnt;
    do_fetch(32'h0000_8044, d, cyc);
    chk(hit_cnt - h0 == 1, "R11 resident before", hit_cnt - h0, 1);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    m0 = miss_cnt;
    do_fetch(32'h0000_8040, d, cyc);
    repeat (20) @(negedge clk);
    chk(miss_cnt - m0 == 1, "R11 miss after clear", miss_cnt - m0, 1);
    chk(d == exp_word(32'h0000_8040), "R3 refill data", d, exp_word(32'h0000_8040));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule